// File: doc/BRIEF.md
# Resonant Lamp Start and Run Sequencer

This block drives the two gates of a half-bridge inverter that feeds a series-resonant lamp circuit. It produces complementary, equal-width pulses with a dead interval at the start of every half period. The operating frequency is held as a half-period count in clock cycles, so a larger count means a lower frequency. Lamp power is set by moving that count, not by changing the duty.

Once the power-factor stage reports that its regulation loop is running, the block takes the lamp through four phases. It first preheats the filaments at the highest frequency. Near the end of preheat it uses the lamp current to decide whether one lamp, two lamps or none are fitted. It then sweeps the frequency down one count per time-base tick towards the ignition frequency, and holds there while it checks that the lamp has struck. A failed strike leads to a second preheat and a fresh sweep, up to a bounded number of attempts.

In run mode the lamp current is multiplied by a fixed bus voltage to give a power figure, and the frequency is stepped once per tick towards a power target that depends on the lamp count. The run logic also detects a lamp that fails or is removed, a lamp that is put back, and over-power. Over-power turns the bridge off and restarts ignition. Too many over-power events shut down both the inverter and the power-factor stage.

Top module: `lamp_seq`

## Requirements
- R1: After reset `seq_state` is OFF, and it stays OFF while `pfc_run` is low. One cycle after `pfc_run` is seen high in OFF, the state becomes PREHEAT. If `pfc_run` drops in any non-terminal state, the next state is OFF, the lamp count returns to 0 and all attempt counters are cleared. State codes: OFF=0, PREHEAT=1, SWEEP=2, HOLD=3, REPRE=4, RUN=5, OCOFF=6, NOLAMP=7, LOCKOUT=8, SHUTDOWN=9.
- R2: Both gates are low in OFF, OCOFF, NOLAMP, LOCKOUT and SHUTDOWN. Only PREHEAT, SWEEP, HOLD, REPRE and RUN drive the bridge.
- R3: With half-period count HP and dead interval DEAD, each gate is high for HP-DEAD cycles per period: `gate_hi` in the first half and `gate_lo` in the second. Both gates are low for the first DEAD cycles of each half, and they are never high together.
- R4: PREHEAT runs at `PRE_HP` for `PRE_TICKS` ticks. On the last tick the lamp current decides the next step: above `TH_TWO` gives a lamp count of 2, from `TH_ONE` to `TH_TWO` inclusive gives 1, and in both cases the state moves to SWEEP. Below `TH_ONE` the state moves to NOLAMP.
- R5: In SWEEP the half-period count rises by exactly 1 on each tick. On the tick that makes it equal to `IGN_HP`, the state moves to HOLD.
- R6: HOLD lasts `HOLD_TICKS` ticks. On the last tick the strike is accepted when the lamp current is strictly above `IGN_TH2` (two lamps) or `IGN_TH1` (one lamp) and the lamp voltage is strictly below `VCOL_TH`. An accepted strike moves the state to RUN.
- R7: A failed strike moves the state to REPRE with the count set to `REPRE_HP`. REPRE lasts `REPRE_TICKS` ticks and then returns to SWEEP. The `MAX_TRIES`-th consecutive failure moves the state to LOCKOUT instead.
- R8: In RUN, on each tick, power = current x `VBUS` is compared with the target (`I_RUN2` x `VBUS` for two lamps, `I_RUN1` x `VBUS` for one). Power below target raises the count by 1 and power above target lowers it by 1. The count is clamped to the range `RUN_MIN_HP` to `RUN_MAX_HP`.
- R9: In RUN with two lamps, a current below 80% of `I_RUN2` on a tick sets the lamp count to 1 and leaves the count unchanged. Regulation then uses the single-lamp target.
- R10: In RUN with one lamp, a current above 120% of `I_RUN1` on a tick sets the lamp count to 2, resets the count to `PRE_HP` and moves the state to SWEEP.
- R11: In RUN, power above 110% of the target on a tick moves the state to OCOFF. The next tick moves it to SWEEP at `PRE_HP`. The over-power event that comes after `MAX_RESTART` such restarts moves the state to SHUTDOWN instead, with `pfc_stop` high.
- R12: NOLAMP, LOCKOUT and SHUTDOWN are terminal until reset, ignore `pfc_run`, and hold `fault` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse that paces the sequence |
| pfc_run | input | 1 | Power-factor stage is in its regulation loop |
| lamp_i | input | I_W | Lamp current sample, mA |
| lamp_v | input | V_W | Rectified lamp voltage sample, mV |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| lamp_cnt | output | 2 | Detected lamp count (0, 1 or 2) |
| seq_state | output | 4 | Sequencer state code (see R1) |
| half_period | output | HP_W | Current half-period count in clock cycles |
| fault | output | 1 | Terminal fault state |
| pfc_stop | output | 1 | Request to shut down the power-factor stage |

## Verification
The bench probes the exact threshold values on both sides. A current of exactly 20 mA must classify as one lamp. A strike current exactly at its threshold, or a lamp voltage exactly at the collapse level, must count as a failed strike. A current of exactly 110% of target must not trip over-power. A design that used the wrong comparison would reach SWEEP with the wrong lamp count, enter RUN too early, or turn the bridge off during normal regulation. The bench also drives the count past both clamp limits, so a missing clamp shows up as a half-period outside the run range. It counts the tries and restarts up to the terminal states, where an off-by-one gives one attempt too many or too few. Finally it measures the gate pulse and dead widths at two frequencies, which would expose a deadband applied to only one half or a bridge that keeps switching in an off state.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
   typedef enum logic [3:0] {
      ST_OFF      = 4'd0,
      ST_PREHEAT  = 4'd1,
      ST_SWEEP    = 4'd2,
      ST_HOLD     = 4'd3,
      ST_REPRE    = 4'd4,
      ST_RUN      = 4'd5,
      ST_OCOFF    = 4'd6,
      ST_NOLAMP   = 4'd7,
      ST_LOCKOUT  = 4'd8,
      ST_SHUTDOWN = 4'd9
   } seq_st_e;

   function automatic logic st_drives(seq_st_e s);
      return (s == ST_PREHEAT) || (s == ST_SWEEP) || (s == ST_HOLD) ||
             (s == ST_REPRE) || (s == ST_RUN);
   endfunction

   function automatic logic st_terminal(seq_st_e s);
      return (s == ST_NOLAMP) || (s == ST_LOCKOUT) || (s == ST_SHUTDOWN);
   endfunction
endpackage

// File: rtl/lamp_seq_gate.sv
module lamp_seq_gate #(
   parameter int HP_W = 12,
   parameter int DEAD = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [HP_W-1:0] hp,
   output logic            gate_hi,
   output logic            gate_lo
);
   logic [HP_W-1:0] cnt_q;
   logic            half_q;
   logic            live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (!en) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else if (cnt_q >= hp - HP_W'(1)) begin
         cnt_q  <= '0;
         half_q <= ~half_q;
      end else begin
         cnt_q  <= cnt_q + HP_W'(1);
      end
   end

   assign live    = en && (cnt_q >= HP_W'(DEAD));
   assign gate_hi = live && !half_q;
   assign gate_lo = live &&  half_q;
endmodule

// File: rtl/lamp_seq_power.sv
module lamp_seq_power #(
   parameter int I_W    = 10,
   parameter int VBUS   = 380,
   parameter int I_RUN1 = 100,
   parameter int I_RUN2 = 200
) (
   input  logic           two_lamps,
   input  logic [I_W-1:0] lamp_i,
   output logic           below,
   output logic           above,
   output logic           over,
   output logic           drop,
   output logic           repl
);
   localparam int VB_W = $clog2(VBUS + 1);
   localparam int CW   = I_W + VB_W + 4;

   logic [CW-1:0] pwr, tgt, icur;

   assign pwr   = CW'(lamp_i) * CW'(VBUS);
   assign tgt   = two_lamps ? CW'(I_RUN2 * VBUS) : CW'(I_RUN1 * VBUS);
   assign icur  = CW'(lamp_i);
   assign below = pwr < tgt;
   assign above = pwr > tgt;
   assign over  = (pwr * CW'(10)) > (tgt * CW'(11));
   assign drop  =  two_lamps && ((icur * CW'(5)) < CW'(I_RUN2 * 4));
   assign repl  = !two_lamps && ((icur * CW'(5)) > CW'(I_RUN1 * 6));
endmodule

// File: rtl/lamp_seq_ctrl.sv
module lamp_seq_ctrl
   import lamp_seq_pkg::*;
#(
   parameter int I_W         = 10,
   parameter int V_W         = 10,
   parameter int HP_W        = 12,
   parameter int PRE_HP      = 781,
   parameter int REPRE_HP    = 812,
   parameter int IGN_HP      = 1562,
   parameter int RUN_MIN_HP  = 781,
   parameter int RUN_MAX_HP  = 1953,
   parameter int PRE_TICKS   = 600,
   parameter int HOLD_TICKS  = 6,
   parameter int REPRE_TICKS = 600,
   parameter int MAX_TRIES   = 5,
   parameter int MAX_RESTART = 6,
   parameter int TH_ONE      = 10,
   parameter int TH_TWO      = 20,
   parameter int IGN_TH1     = 30,
   parameter int IGN_TH2     = 100,
   parameter int VCOL_TH     = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            pfc_run,
   input  logic [I_W-1:0]  lamp_i,
   input  logic [V_W-1:0]  lamp_v,
   input  logic            below,
   input  logic            above,
   input  logic            over,
   input  logic            drop,
   input  logic            repl,
   output seq_st_e         st,
   output logic [HP_W-1:0] hp,
   output logic [1:0]      lamps
);
   localparam int TMAX  = (PRE_TICKS > REPRE_TICKS) ?
                          ((PRE_TICKS > HOLD_TICKS) ? PRE_TICKS : HOLD_TICKS) :
                          ((REPRE_TICKS > HOLD_TICKS) ? REPRE_TICKS : HOLD_TICKS);
   localparam int TMR_W = $clog2(TMAX + 1);
   localparam int TRY_W = $clog2(MAX_TRIES + 1);
   localparam int OC_W  = $clog2(MAX_RESTART + 1);

   logic [TMR_W-1:0] tmr;
   logic [TRY_W-1:0] tries;
   logic [OC_W-1:0]  oc;
   logic             struck;

   assign struck = ((lamps == 2'd2) ? (lamp_i > I_W'(IGN_TH2)) : (lamp_i > I_W'(IGN_TH1)))
                   && (lamp_v < V_W'(VCOL_TH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_OFF; hp <= HP_W'(PRE_HP); tmr <= '0;
         tries <= '0; oc <= '0; lamps <= 2'd0;
      end else if (!pfc_run && !st_terminal(st)) begin
         st <= ST_OFF; hp <= HP_W'(PRE_HP); tmr <= '0;
         tries <= '0; oc <= '0; lamps <= 2'd0;
      end else begin
         case (st)
            ST_OFF: begin
               st  <= ST_PREHEAT;
               hp  <= HP_W'(PRE_HP);
               tmr <= '0;
            end
            ST_PREHEAT: if (tick) begin
               if (tmr == TMR_W'(PRE_TICKS - 1)) begin
                  tmr <= '0;
                  if (lamp_i > I_W'(TH_TWO)) begin
                     lamps <= 2'd2; st <= ST_SWEEP;
                  end else if (lamp_i >= I_W'(TH_ONE)) begin
                     lamps <= 2'd1; st <= ST_SWEEP;
                  end else begin
                     st <= ST_NOLAMP;
                  end
               end else begin
                  tmr <= tmr + TMR_W'(1);
               end
            end
            ST_SWEEP: if (tick) begin
               hp <= hp + HP_W'(1);
               if (hp + HP_W'(1) == HP_W'(IGN_HP)) begin
                  st <= ST_HOLD; tmr <= '0;
               end
            end
            ST_HOLD: if (tick) begin
               if (tmr == TMR_W'(HOLD_TICKS - 1)) begin
                  tmr <= '0;
                  if (struck) begin
                     st <= ST_RUN; tries <= '0;
                  end else if (tries == TRY_W'(MAX_TRIES - 1)) begin
                     st <= ST_LOCKOUT;
                  end else begin
                     tries <= tries + TRY_W'(1);
                     st    <= ST_REPRE;
                     hp    <= HP_W'(REPRE_HP);
                  end
               end else begin
                  tmr <= tmr + TMR_W'(1);
               end
            end
            ST_REPRE: if (tick) begin
               if (tmr == TMR_W'(REPRE_TICKS - 1)) begin
                  tmr <= '0; st <= ST_SWEEP;
               end else begin
                  tmr <= tmr + TMR_W'(1);
               end
            end
            ST_RUN: if (tick) begin
               if (repl) begin
                  lamps <= 2'd2; hp <= HP_W'(PRE_HP); st <= ST_SWEEP;
               end else if (over) begin
                  if (oc == OC_W'(MAX_RESTART)) begin
                     st <= ST_SHUTDOWN;
                  end else begin
                     oc <= oc + OC_W'(1); st <= ST_OCOFF;
                  end
               end else if (drop) begin
                  lamps <= 2'd1;
               end else if (below && (hp < HP_W'(RUN_MAX_HP))) begin
                  hp <= hp + HP_W'(1);
               end else if (above && (hp > HP_W'(RUN_MIN_HP))) begin
                  hp <= hp - HP_W'(1);
               end
            end
            ST_OCOFF: if (tick) begin
               hp <= HP_W'(PRE_HP); st <= ST_SWEEP;
            end
            default: st <= st;
         endcase
      end
   end
endmodule

// File: rtl/lamp_seq.sv
module lamp_seq
   import lamp_seq_pkg::*;
#(
   parameter int I_W         = 10,
   parameter int V_W         = 10,
   parameter int HP_W        = 12,
   parameter int DEAD        = 16,
   parameter int PRE_HP      = 781,
   parameter int REPRE_HP    = 812,
   parameter int IGN_HP      = 1562,
   parameter int RUN_MIN_HP  = 781,
   parameter int RUN_MAX_HP  = 1953,
   parameter int PRE_TICKS   = 600,
   parameter int HOLD_TICKS  = 6,
   parameter int REPRE_TICKS = 600,
   parameter int MAX_TRIES   = 5,
   parameter int MAX_RESTART = 6,
   parameter int TH_ONE      = 10,
   parameter int TH_TWO      = 20,
   parameter int IGN_TH1     = 30,
   parameter int IGN_TH2     = 100,
   parameter int VCOL_TH     = 200,
   parameter int VBUS        = 380,
   parameter int I_RUN1      = 100,
   parameter int I_RUN2      = 200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            pfc_run,
   input  logic [I_W-1:0]  lamp_i,
   input  logic [V_W-1:0]  lamp_v,
   output logic            gate_hi,
   output logic            gate_lo,
   output logic [1:0]      lamp_cnt,
   output logic [3:0]      seq_state,
   output logic [HP_W-1:0] half_period,
   output logic            fault,
   output logic            pfc_stop
);
   if (DEAD < 1 || PRE_HP <= DEAD) begin : g_bad_dead
      initial $fatal(1, "deadband must be at least 1 and below the shortest half period");
   end
   if (!(PRE_HP < REPRE_HP && REPRE_HP < IGN_HP && IGN_HP <= RUN_MAX_HP)) begin : g_bad_order
      initial $fatal(1, "half-period counts must rise from preheat to ignition");
   end
   if (RUN_MIN_HP < PRE_HP || RUN_MAX_HP >= (1 << HP_W)) begin : g_bad_range
      initial $fatal(1, "run half-period range does not fit");
   end
   if (PRE_TICKS < 1 || HOLD_TICKS < 1 || REPRE_TICKS < 1 || MAX_TRIES < 1) begin : g_bad_time
      initial $fatal(1, "phase lengths and tries must be at least 1");
   end

   seq_st_e st;
   logic [1:0] lamps;
   logic below, above, over, drop, repl;

   lamp_seq_power #(.I_W(I_W), .VBUS(VBUS), .I_RUN1(I_RUN1), .I_RUN2(I_RUN2)) pwr_i (
      .two_lamps (lamps == 2'd2),
      .lamp_i    (lamp_i),
      .below     (below),
      .above     (above),
      .over      (over),
      .drop      (drop),
      .repl      (repl)
   );

   lamp_seq_ctrl #(
      .I_W(I_W), .V_W(V_W), .HP_W(HP_W), .PRE_HP(PRE_HP), .REPRE_HP(REPRE_HP),
      .IGN_HP(IGN_HP), .RUN_MIN_HP(RUN_MIN_HP), .RUN_MAX_HP(RUN_MAX_HP),
      .PRE_TICKS(PRE_TICKS), .HOLD_TICKS(HOLD_TICKS), .REPRE_TICKS(REPRE_TICKS),
      .MAX_TRIES(MAX_TRIES), .MAX_RESTART(MAX_RESTART), .TH_ONE(TH_ONE),
      .TH_TWO(TH_TWO), .IGN_TH1(IGN_TH1), .IGN_TH2(IGN_TH2), .VCOL_TH(VCOL_TH)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pfc_run(pfc_run),
      .lamp_i(lamp_i), .lamp_v(lamp_v), .below(below), .above(above),
      .over(over), .drop(drop), .repl(repl),
      .st(st), .hp(half_period), .lamps(lamps)
   );

   lamp_seq_gate #(.HP_W(HP_W), .DEAD(DEAD)) gate_i (
      .clk(clk), .rst_n(rst_n), .en(st_drives(st)), .hp(half_period),
      .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   assign lamp_cnt  = lamps;
   assign seq_state = st;
   assign fault     = st_terminal(st);
   assign pfc_stop  = (st == ST_SHUTDOWN);
endmodule

// File: rtl/lamp_seq_chk.sv
module lamp_seq_chk #(
   parameter int HP_W       = 12,
   parameter int RUN_MIN_HP = 781,
   parameter int RUN_MAX_HP = 1953
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            pfc_run,
   input logic            gate_hi,
   input logic            gate_lo,
   input logic [3:0]      seq_state,
   input logic [HP_W-1:0] half_period,
   input logic            fault,
   input logic            pfc_stop
);
   // R3: the two gates are never high together
   a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi && gate_lo));

   // R2: non-driving states keep both gates low
   a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'd0 || seq_state >= 4'd6) |-> (!gate_hi && !gate_lo));

   // R1: OFF is held while the power-factor stage is not running
   a_r1_wait_pfc: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'd0 && !pfc_run) |=> (seq_state == 4'd0));

   // R5: the sweep moves the count by at most one step
   a_r5_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'd2 && $past(seq_state) == 4'd2) |->
         (half_period == $past(half_period) ||
          half_period == $past(half_period) + HP_W'(1)));

   // R8: run mode stays within the frequency limits
   a_r8_run_range: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'd5) |->
         (half_period >= HP_W'(RUN_MIN_HP) && half_period <= HP_W'(RUN_MAX_HP)));

   // R11: shutdown requests that the power-factor stage stop
   a_r11_pfc_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == 4'd9) |-> pfc_stop);

   // R12: terminal states stay put and flag a fault
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state >= 4'd7) |=> (seq_state == $past(seq_state) && fault));
endmodule

bind lamp_seq lamp_seq_chk #(
   .HP_W(HP_W), .RUN_MIN_HP(RUN_MIN_HP), .RUN_MAX_HP(RUN_MAX_HP)
) chk_i (
   .clk(clk), .rst_n(rst_n), .tick(tick), .pfc_run(pfc_run),
   .gate_hi(gate_hi), .gate_lo(gate_lo), .seq_state(seq_state),
   .half_period(half_period), .fault(fault), .pfc_stop(pfc_stop)
);

// File: tb/lamp_seq_tb.sv
module lamp_seq_tb_top;
   localparam int DEAD = 2, PRE = 8, REPRE = 9, IGN = 14, RMIN = 8, RMAX = 20;
   localparam int PT = 3, HT = 2, RT = 3, TRIES = 3, RESTART = 6;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pfc_run = 1'b0;
   logic [9:0] lamp_i = '0, lamp_v = '0;
   logic gate_hi, gate_lo, fault, pfc_stop;
   logic [1:0] lamp_cnt;
   logic [3:0] seq_state;
   logic [11:0] half_period;
   int checks = 0, errors = 0, cyc = 0;

   always #4 clk = ~clk;

   lamp_seq #(
      .DEAD(DEAD), .PRE_HP(PRE), .REPRE_HP(REPRE), .IGN_HP(IGN),
      .RUN_MIN_HP(RMIN), .RUN_MAX_HP(RMAX), .PRE_TICKS(PT), .HOLD_TICKS(HT),
      .REPRE_TICKS(RT), .MAX_TRIES(TRIES), .MAX_RESTART(RESTART)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pfc_run(pfc_run),
      .lamp_i(lamp_i), .lamp_v(lamp_v), .gate_hi(gate_hi), .gate_lo(gate_lo),
      .lamp_cnt(lamp_cnt), .seq_state(seq_state), .half_period(half_period),
      .fault(fault), .pfc_stop(pfc_stop)
   );

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: act running exp finished");
         report();
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act %0d exp %0d", req, act, exp);
      end
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; pfc_run = 1'b0; tick = 1'b0; lamp_i = '0; lamp_v = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic measure(string req, int hp);
      int hc = 0, gc = 0, lc = 0;
      while (!gate_lo) @(negedge clk);
      while (!gate_hi) @(negedge clk);
      while (gate_hi) begin hc++; @(negedge clk); end
      while (!gate_hi && !gate_lo) begin gc++; @(negedge clk); end
      while (gate_lo) begin lc++; @(negedge clk); end
      chk({req, " high width"}, hc, hp - DEAD);
      chk({req, " dead width"}, gc, DEAD);
      chk({req, " low width"}, lc, hp - DEAD);
   endtask

   initial begin
      // Scenario A: reset, one lamp, three failed strikes
      do_reset();
      chk("R1 reset state", seq_state, 0);
      chk("R2 reset gates", {gate_hi, gate_lo}, 0);
      chk("R1 reset lamp count", lamp_cnt, 0);
      chk("R12 reset fault", {fault, pfc_stop}, 0);
      ticks(2);
      chk("R1 waits for pfc", seq_state, 0);
      pfc_run = 1'b1;
      @(negedge clk);
      chk("R4 preheat state", seq_state, 1);
      chk("R4 preheat count", half_period, PRE);
      measure("R3 preheat", PRE);
      lamp_i = 10'd20;
      ticks(PT - 1);
      chk("R4 preheat length", seq_state, 1);
      ticks(1);
      chk("R4 20mA is one lamp", lamp_cnt, 1);
      chk("R4 to sweep", seq_state, 2);
      for (int k = 1; k <= IGN - PRE; k++) begin
         ticks(1);
         chk("R5 sweep step", half_period, PRE + k);
         if (k == IGN - PRE - 1) chk("R5 still sweeping", seq_state, 2);
      end
      chk("R5 hold reached", seq_state, 3);
      lamp_i = 10'd30; lamp_v = 10'd100;
      ticks(HT);
      chk("R6 30mA is no strike", seq_state, 4);
      chk("R7 repreheat count", half_period, REPRE);
      ticks(RT);
      chk("R7 back to sweep", seq_state, 2);
      ticks(IGN - REPRE);
      chk("R5 hold again", seq_state, 3);
      lamp_i = 10'd31; lamp_v = 10'd200;
      ticks(HT);
      chk("R6 200mV is no collapse", seq_state, 4);
      ticks(RT + IGN - REPRE + HT);
      chk("R7 lockout after tries", seq_state, 8);
      chk("R12 lockout fault", fault, 1);
      chk("R2 lockout gates", {gate_hi, gate_lo}, 0);
      pfc_run = 1'b0;
      ticks(2);
      chk("R12 lockout sticky", seq_state, 8);

      // Scenario B: pfc loss and empty fixture
      do_reset();
      pfc_run = 1'b1;
      @(negedge clk);
      pfc_run = 1'b0;
      @(negedge clk);
      chk("R1 pfc loss to off", seq_state, 0);
      pfc_run = 1'b1; lamp_i = 10'd9;
      @(negedge clk);
      ticks(PT);
      chk("R4 9mA is no lamp", seq_state, 7);
      chk("R12 no-lamp fault", fault, 1);
      chk("R2 no-lamp gates", {gate_hi, gate_lo}, 0);

      // Scenario C: two lamps, regulation, lamp loss and return, over-power
      do_reset();
      pfc_run = 1'b1; lamp_i = 10'd21;
      @(negedge clk);
      ticks(PT);
      chk("R4 21mA is two lamps", lamp_cnt, 2);
      ticks(IGN - PRE);
      lamp_i = 10'd101; lamp_v = 10'd199;
      ticks(HT);
      chk("R6 strike accepted", seq_state, 5);
      chk("R6 run starts at ignition", half_period, IGN);
      lamp_i = 10'd180;
      ticks(3);
      chk("R8 low power lowers freq", half_period, IGN + 3);
      ticks(5);
      chk("R8 upper clamp", half_period, RMAX);
      measure("R3 run", RMAX);
      lamp_i = 10'd210;
      ticks(RMAX - RMIN + 2);
      chk("R8 lower clamp", half_period, RMIN);
      lamp_i = 10'd220;
      ticks(1);
      chk("R11 110% not over", seq_state, 5);
      lamp_i = 10'd159;
      ticks(1);
      chk("R9 lamp loss count", lamp_cnt, 1);
      chk("R9 count kept", half_period, RMIN);
      lamp_i = 10'd95;
      ticks(1);
      chk("R9 single target", half_period, RMIN + 1);
      lamp_i = 10'd110;
      ticks(1);
      chk("R11 single 110% not over", seq_state, 5);
      chk("R8 step down", half_period, RMIN);
      lamp_i = 10'd121;
      ticks(1);
      chk("R10 lamp back count", lamp_cnt, 2);
      chk("R10 resweep", seq_state, 2);
      chk("R10 steps to preheat freq", half_period, PRE);
      lamp_i = 10'd221; lamp_v = 10'd0;
      for (int r = 0; r < RESTART; r++) begin
         ticks(IGN - PRE + HT);
         chk("R11 rerun reached", seq_state, 5);
         ticks(1);
         chk("R11 over-power off", seq_state, 6);
         chk("R2 over-power gates", {gate_hi, gate_lo}, 0);
         ticks(1);
         chk("R11 restart sweep", seq_state, 2);
         chk("R11 restart count", half_period, PRE);
      end
      ticks(IGN - PRE + HT + 1);
      chk("R11 shutdown", seq_state, 9);
      chk("R11 pfc stop", pfc_stop, 1);
      ticks(2);
      chk("R12 shutdown sticky", seq_state, 9);
      report();
   end
endmodule